// File: doc/BRIEF.md
# TDD Slot and Hop Scheduler

This block is the master-side slot timer of a frequency-hopping, time-division duplex radio link. It counts a 1 MHz enable into fixed slots of 625 ticks. Each slot is either a master-transmit slot or a slave-response slot. Every slot gets a channel index from a free-running pseudo-random sequence that advances once per slot. A master packet may span one, three or five consecutive slots. Its channel stays fixed for the whole packet, and it is always followed by one response slot from the slave it addressed.

Frames rotate round-robin among the active slaves given by a seven-bit mask. When no slave is active, the slots keep alternating direction and the hop sequence keeps moving, but no packet is scheduled. The slot strobe opens each slot. The direction, channel, slave address and packet flag for the new slot appear one clock after the strobe and then stay unchanged until the next strobe. There is no data stream at this block's edge: all pins are plain control and status levels, with no handshake.

Top module: `tdd_hop_sched`

## Requirements
- R1: A slot is exactly 625 ticks of `tick_i`. `slot_strobe_o` is high for one clock, in the cycle that carries the first tick of a slot. Cycles without a tick advance nothing, and outputs change only in the clock that follows a strobe.
- R2: `dir_tx_o` is 1 in master-transmit slots and 0 in response slots. Each master packet is followed by exactly one response slot, and each response slot is followed by a new master packet.
- R3: The hop value for a slot is a 16-bit Fibonacci LFSR state taken modulo 79, so the channel is always 0 to 78. The LFSR shifts left and inserts the XOR of state bits 15, 13, 12 and 10 (tap mask 0xB400). It is seeded with 0xACE1 and steps once per slot, whatever kind of slot it is.
- R4: All slots of one master packet use the channel of that packet's first slot. Any slot that starts a packet, and every response slot, uses the hop of its own slot number. For example, after a 3-slot packet that starts on hop k, the response slot uses hop k+3.
- R5: `len_req_i` values 1, 3 and 5 give a master packet of that many slots; every other value gives 1. The length is read only at the strobe of a packet's first slot, and changes at other times have no effect.
- R6: Bit i of `slv_mask_i` marks slave address i+1 as active. Each new packet addresses the next active slave after the previously addressed one, counting upward from 1 to 7 and wrapping. The response slot keeps the same address, and `pkt_on_o` is 1 for both the packet and its response.
- R7: With an all-zero mask at a packet start, that slot and the following response slot carry `pkt_on_o`=0 and `slave_o`=0. The packet length counts as 1 whatever `len_req_i` holds, and the direction and hop keep advancing.
- R8: After a synchronous reset, and until the first strobe, the outputs read `dir_tx_o`=1, `chan_o`=0, `slave_o`=0 and `pkt_on_o`=0. The first slot is a packet start with channel 0xACE1 mod 79 = 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | 1 MHz enable, one clock per microsecond |
| len_req_i | input | 3 | Requested length of the next master packet, in slots |
| slv_mask_i | input | 7 | Active slaves; bit i stands for address i+1 |
| slot_strobe_o | output | 1 | First tick of a slot |
| dir_tx_o | output | 1 | 1 in a master-transmit slot, 0 in a response slot |
| chan_o | output | 7 | Channel index for the current slot, 0 to 78 |
| slave_o | output | 3 | Slave addressed in the current frame, 0 when idle |
| pkt_on_o | output | 1 | The current slot belongs to a scheduled frame |

## Verification
The hardest case to reach is an input change while a multi-slot packet is already running. The requested length or the slave mask changes on a strobe that opens a continuation slot, and a correct block must ignore it until the next packet start. The stimulus therefore changes `len_req_i` on every slot for a stretch and changes the mask in the middle of a five-slot packet. A scoreboard predicts every slot's direction, channel and address from the input values seen at each strobe. A tick stall inside a slot checks that the slot still lasts exactly 625 ticks.

// File: rtl/tdd_pkg.sv
package tdd_pkg;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_CONT  = 2'd1,
    PH_REPLY = 2'd2
  } phase_e;

  // Legal packet lengths pass through, anything else collapses to one slot
  function automatic logic [2:0] legal_len(input logic [2:0] req);
    case (req)
      3'd3, 3'd5: legal_len = req;
      default:    legal_len = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/tdd_tick_timer.sv
module tdd_tick_timer #(
  parameter int SLOT_TICKS = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic slot_start
);
  localparam int CW = $clog2(SLOT_TICKS);
  localparam logic [CW-1:0] LAST = CW'(SLOT_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign slot_start = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tdd_hop_lfsr.sv
module tdd_hop_lfsr #(
  parameter int              W      = 16,
  parameter logic [W-1:0]    SEED   = 16'hACE1,
  parameter logic [W-1:0]    TAPS   = 16'hB400,
  parameter int              NUM_CH = 79,
  localparam int             CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  output logic [CH_W-1:0] hop
);
  logic [W-1:0] state_q;
  logic [W-1:0] residue;
  logic         fb;

  assign fb      = ^(state_q & TAPS);
  assign residue = state_q % W'(NUM_CH);
  assign hop     = residue[CH_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (step) begin
      state_q <= {state_q[W-2:0], fb};
    end
  end
endmodule

// File: rtl/tdd_rr_pick.sv
module tdd_rr_pick #(
  parameter int  N  = 7,
  localparam int AW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mask,
  input  logic [AW-1:0] last,
  output logic [AW-1:0] pick,
  output logic          any
);
  // Scan offsets from far to near so the nearest active address wins
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int k = N; k >= 1; k--) begin
      int cand;
      cand = ((int'(last) - 1 + k) % N) + 1;
      if (mask[cand-1]) begin
        pick = AW'(cand);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdd_hop_sched.sv
module tdd_hop_sched #(
  parameter int            SLOT_TICKS = 625,
  parameter int            NUM_CH     = 79,
  parameter int            LFSR_W     = 16,
  parameter logic [15:0]   LFSR_SEED  = 16'hACE1,
  parameter logic [15:0]   LFSR_TAPS  = 16'hB400,
  parameter int            SLV_N      = 7,
  localparam int           CH_W       = $clog2(NUM_CH),
  localparam int           AW         = $clog2(SLV_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [2:0]       len_req_i,
  input  logic [SLV_N-1:0] slv_mask_i,
  output logic             slot_strobe_o,
  output logic             dir_tx_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [AW-1:0]    slave_o,
  output logic             pkt_on_o
);
  import tdd_pkg::*;

  logic            strobe;
  logic [CH_W-1:0] hop;
  logic [AW-1:0]   pick;
  logic            any_act;
  logic [AW-1:0]   last_q;
  logic [2:0]      rem_q;
  logic [2:0]      start_len;
  phase_e          phase_q;

  tdd_tick_timer #(.SLOT_TICKS(SLOT_TICKS)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_i),
    .slot_start (strobe)
  );

  tdd_hop_lfsr #(
    .W      (LFSR_W),
    .SEED   (LFSR_W'(LFSR_SEED)),
    .TAPS   (LFSR_W'(LFSR_TAPS)),
    .NUM_CH (NUM_CH)
  ) u_hop (
    .clk  (clk),
    .rst  (rst),
    .step (strobe),
    .hop  (hop)
  );

  tdd_rr_pick #(.N(SLV_N)) u_rr (
    .mask (slv_mask_i),
    .last (last_q),
    .pick (pick),
    .any  (any_act)
  );

  // An idle frame (no active slave) is always one master slot long
  assign start_len     = any_act ? legal_len(len_req_i) : 3'd1;
  assign slot_strobe_o = strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_START;
      rem_q    <= '0;
      last_q   <= AW'(SLV_N);
      dir_tx_o <= 1'b1;
      chan_o   <= '0;
      slave_o  <= '0;
      pkt_on_o <= 1'b0;
    end else if (strobe) begin
      case (phase_q)
        PH_START: begin
          dir_tx_o <= 1'b1;
          chan_o   <= hop;
          pkt_on_o <= any_act;
          slave_o  <= any_act ? pick : '0;
          if (any_act) last_q <= pick;
          rem_q    <= start_len - 3'd1;
          phase_q  <= (start_len == 3'd1) ? PH_REPLY : PH_CONT;
        end
        PH_CONT: begin
          dir_tx_o <= 1'b1;
          rem_q    <= rem_q - 3'd1;
          phase_q  <= (rem_q == 3'd1) ? PH_REPLY : PH_CONT;
        end
        default: begin
          dir_tx_o <= 1'b0;
          chan_o   <= hop;
          phase_q  <= PH_START;
        end
      endcase
    end
  end
endmodule

// File: rtl/tdd_hop_sched_chk.sv
module tdd_hop_sched_chk #(
  parameter int NUM_CH = 79,
  parameter int CH_W   = 7,
  parameter int AW     = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            tick_i,
  input logic            slot_strobe_o,
  input logic            dir_tx_o,
  input logic [CH_W-1:0] chan_o,
  input logic [AW-1:0]   slave_o,
  input logic            pkt_on_o
);
  p_strobe_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    slot_strobe_o |-> tick_i);

  p_single_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    slot_strobe_o |=> !slot_strobe_o);

  p_hold_between_r1: assert property (@(posedge clk) disable iff (rst)
    !slot_strobe_o |=> $stable({dir_tx_o, chan_o, slave_o, pkt_on_o}));

  p_master_after_reply_r2: assert property (@(posedge clk) disable iff (rst)
    (slot_strobe_o && !dir_tx_o) |=> dir_tx_o);

  p_chan_range_r3: assert property (@(posedge clk) disable iff (rst)
    chan_o < CH_W'(NUM_CH));

  p_reply_keeps_slave_r6: assert property (@(posedge clk) disable iff (rst)
    (slot_strobe_o && dir_tx_o) ##1 !dir_tx_o |-> $stable({slave_o, pkt_on_o}));

  p_active_has_addr_r6: assert property (@(posedge clk) disable iff (rst)
    pkt_on_o |-> slave_o != '0);

  p_idle_no_addr_r7: assert property (@(posedge clk) disable iff (rst)
    !pkt_on_o |-> slave_o == '0);
endmodule

bind tdd_hop_sched tdd_hop_sched_chk #(
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W),
  .AW     (AW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tick_i        (tick_i),
  .slot_strobe_o (slot_strobe_o),
  .dir_tx_o      (dir_tx_o),
  .chan_o        (chan_o),
  .slave_o       (slave_o),
  .pkt_on_o      (pkt_on_o)
);

// File: tb/tdd_hop_sched_test.sv
`timescale 1ns/1ps
module tdd_hop_sched_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick_i;
  logic [2:0] len_req_i;
  logic [6:0] slv_mask_i;
  logic       slot_strobe_o;
  logic       dir_tx_o;
  logic [6:0] chan_o;
  logic [2:0] slave_o;
  logic       pkt_on_o;

  always #2.5 clk = ~clk;

  tdd_hop_sched uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .len_req_i(len_req_i),
    .slv_mask_i(slv_mask_i), .slot_strobe_o(slot_strobe_o),
    .dir_tx_o(dir_tx_o), .chan_o(chan_o), .slave_o(slave_o),
    .pkt_on_o(pkt_on_o)
  );

  typedef struct packed {
    logic       dir;
    logic [6:0] chan;
    logic [2:0] slave;
    logic       pkt;
  } exp_t;

  exp_t  sb_q[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;

  // Reference model state, built from the requirements
  logic [15:0] b_lfsr  = 16'hACE1;
  int          b_ph    = 0;
  int          b_rem   = 0;
  int          b_last  = 7;
  int          b_slave = 0;
  bit          b_pkt   = 0;
  int          b_chan  = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver side: predicts the slot opened by the strobe just seen
  task automatic push_expect();
    exp_t e;
    int   lv;
    int   hopv;
    hopv = int'(b_lfsr % 16'd79);
    case (b_ph)
      0: begin
        lv = (len_req_i == 3'd3 || len_req_i == 3'd5) ? int'(len_req_i) : 1;
        if (slv_mask_i == 7'd0) begin
          lv = 1; b_pkt = 0; b_slave = 0;
        end else begin
          for (int k = 7; k >= 1; k--) begin
            int c;
            c = ((b_last - 1 + k) % 7) + 1;
            if (slv_mask_i[c-1]) b_slave = c;
          end
          b_last = b_slave; b_pkt = 1;
        end
        b_chan = hopv; e.dir = 1'b1;
        b_rem = lv - 1; b_ph = (lv == 1) ? 2 : 1;
      end
      1: begin
        e.dir = 1'b1; b_rem--;
        if (b_rem == 0) b_ph = 2;
      end
      default: begin
        e.dir = 1'b0; b_chan = hopv; b_ph = 0;
      end
    endcase
    e.chan  = 7'(b_chan);
    e.slave = 3'(b_slave);
    e.pkt   = b_pkt;
    sb_q.push_back(e);
    b_lfsr = {b_lfsr[14:0], ^(b_lfsr & 16'hB400)};
  endtask

  // Monitor: compares each slot's outputs one clock after its strobe
  bit pend = 0;
  bit first_strobe = 1;
  bit first_cmp = 1;
  int tick_cnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pend) begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R2 direction", int'(dir_tx_o), int'(e.dir));
        chk("R3 R4 channel", int'(chan_o), int'(e.chan));
        chk("R6 R7 slave", int'(slave_o), int'(e.slave));
        chk("R6 R7 packet flag", int'(pkt_on_o), int'(e.pkt));
        chk("R3 range", int'(chan_o < 7'd79), 1);
        if (first_cmp) chk("R8 first hop", int'(chan_o), 17);
        first_cmp = 0;
        pend = 0;
      end
      if (slot_strobe_o) begin
        if (!first_strobe) chk("R1 ticks per slot", tick_cnt, 625);
        first_strobe = 0;
        tick_cnt = 1;
        push_expect();
        pend = 1;
      end else if (tick_i) begin
        tick_cnt++;
      end
    end
  end

  task automatic wait_slots(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!slot_strobe_o);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    rst = 1; tick_i = 0; len_req_i = 3'd1; slv_mask_i = 7'd0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset dir", int'(dir_tx_o), 1);
    chk("R8 reset chan", int'(chan_o), 0);
    chk("R8 reset slave", int'(slave_o), 0);
    chk("R8 reset pkt", int'(pkt_on_o), 0);
    @(posedge clk); #1 tick_i = 1;
    // R7: no active slave, hops keep running
    len_req_i = 3'd5;
    wait_slots(4);
    // R6: two slaves, single-slot packets
    slv_mask_i = 7'b0000101; len_req_i = 3'd1;
    wait_slots(8);
    // R4: three-slot packets
    slv_mask_i = 7'b1010010; len_req_i = 3'd3;
    wait_slots(12);
    // R4: five-slot packets
    len_req_i = 3'd5;
    wait_slots(12);
    // R5: illegal codes map to one slot
    len_req_i = 3'd2; wait_slots(4);
    len_req_i = 3'd6; wait_slots(4);
    len_req_i = 3'd7; wait_slots(4);
    len_req_i = 3'd0; wait_slots(4);
    // R5: request changes every slot, only packet starts count
    for (int i = 0; i < 10; i++) begin
      len_req_i = (i % 2 == 0) ? 3'd5 : 3'd1;
      wait_slots(1);
    end
    // R1: tick stall inside a slot; mask change mid-packet (R6)
    len_req_i = 3'd5;
    wait_slots(2);
    slv_mask_i = 7'b1000000;
    repeat (100) @(posedge clk);
    #1 tick_i = 0;
    repeat (40) @(posedge clk);
    #1 tick_i = 1;
    wait_slots(6);
    // R6: all seven slaves
    slv_mask_i = 7'b1111111; len_req_i = 3'd3;
    wait_slots(14);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule